// File: doc/BRIEF.md
# Lockable Header Address Scrambler

This block sits between the CPU address bus and the low address pins of a cartridge ROM. It produces the low ROM address byte from the 16-bit CPU address. Inside the header window, a fixed bit permutation is applied to four of the low lines, so that a header stored scrambled in ROM reads back in plain order. Outside that window, every line follows its matching CPU address bit.

The block also contains a lock. From reset it is locked, and while locked it drives the bit-7 ROM line high whatever the CPU presents on address bit 7. A boot program that reads the logo area therefore sees an alternate copy of the logo. The CPU unlocks the block by producing 49 high-to-low transitions on address bit 15. Only a reset locks the block again. The permutation works the same whether the block is locked or not.

A15 is brought into the clock domain through a two-flop synchronizer, and the lock flag is a register. Apart from that flag, the path from address to ROM lines is combinational.

Top module: `addr_scrambler`

## Requirements
- R1: After reset is released the block is locked: rom_lo[7] is 1 for every value of cpu_addr[7].
- R2: Each high-to-low transition of cpu_addr[15] advances an unlock count. After the 48th transition the block is still locked. Once the 49th transition is detected, rom_lo[7] equals cpu_addr[7], at the latest four clock cycles after the falling edge.
- R3: Transitions on any cpu_addr bit other than bit 15 do not advance the unlock count.
- R4: Once unlocked, the block stays unlocked whatever further transitions occur, until rst_n is asserted. After a reset it is locked again.
- R5: When cpu_addr[8] is 1 and cpu_addr[15:9] are all 0 (the header window), rom_lo[0]=cpu_addr[6], rom_lo[1]=cpu_addr[4], rom_lo[4]=cpu_addr[1] and rom_lo[6]=cpu_addr[0].
- R6: Outside the header window, rom_lo[0], rom_lo[1], rom_lo[4] and rom_lo[6] equal cpu_addr bits 0, 1, 4 and 6.
- R7: Inside the header window rom_lo[7] is not permuted. It is 1 while locked and equals cpu_addr[7] once unlocked.
- R8: rom_lo[2], rom_lo[3] and rom_lo[5] always equal cpu_addr bits 2, 3 and 5, whether locked or not and whether inside the window or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| cpu_addr | input | 16 | CPU address bus |
| rom_lo | output | 8 | Low byte of the ROM address (lines 0 to 7) |

## Verification
The assertions check every cycle that the count moves up only in steps of one, that the lock flag rises exactly when the count reaches its limit and never falls afterwards, that bit 7 stays high while the count is short of the limit, and that the four permuted lines carry the same number of ones as their source bits. Only the bench scenarios can show the exact behaviour at the boundary: locked after 48 edges and open after 49. They also show that other address bits never advance the count, that the exact permutation applies inside the window and plain passthrough applies outside it, and that a reset locks the block again.

// File: rtl/addr_scrambler_pkg.sv
package addr_scrambler_pkg;
  // Source bit index for each low ROM line inside the header window.
  function automatic int unsigned hdr_src(input int unsigned line);
    case (line)
      0:       return 6;
      1:       return 4;
      4:       return 1;
      6:       return 0;
      default: return line;
    endcase
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb stage_d = {stage_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/unlock_ctr.sv
module unlock_ctr #(
  parameter int unsigned UNLOCK_EDGES = 49,
  localparam int unsigned CW = $clog2(UNLOCK_EDGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  output logic [CW-1:0] count_o,
  output logic          unlocked_o
);
  localparam logic [CW-1:0] LIMIT = CW'(UNLOCK_EDGES);

  logic          lvl_prev_q;
  logic          fall;
  logic          sat;
  logic          cnt_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          open_q, open_d;

  always_comb begin
    fall   = lvl_prev_q & ~lvl_i;
    sat    = (cnt_q == LIMIT);
    cnt_en = fall & ~sat;
    cnt_d  = cnt_q + CW'(1);
    open_d = open_q | (cnt_en & (cnt_d == LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      cnt_q      <= '0;
      open_q     <= 1'b0;
    end else begin
      lvl_prev_q <= lvl_i;
      if (cnt_en) cnt_q <= cnt_d;
      open_q <= open_d;
    end
  end

  assign count_o    = cnt_q;
  assign unlocked_o = open_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1))); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R2
  AST_STAY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(open_q) |-> open_q); // R4
endmodule

// File: rtl/hdr_perm.sv
module hdr_perm
  import addr_scrambler_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned WIN_BIT = 8
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            unlocked_i,
  output logic [LO_W-1:0] lo_o
);
  localparam int unsigned LOCK_BIT = LO_W - 1;

  logic in_win;
  assign in_win = addr_i[WIN_BIT] & ~(|addr_i[AW-1:WIN_BIT+1]);

  for (genvar i = 0; i < LO_W; i++) begin : g_line
    if (i == LOCK_BIT) begin : g_lock
      assign lo_o[i] = addr_i[i] | ~unlocked_i;
    end else if (hdr_src(i) != i) begin : g_perm
      assign lo_o[i] = in_win ? addr_i[hdr_src(i)] : addr_i[i];
    end else begin : g_pass
      assign lo_o[i] = addr_i[i];
    end
  end
endmodule

// File: rtl/addr_scrambler.sv
module addr_scrambler #(
  parameter int unsigned AW           = 16,
  parameter int unsigned UNLOCK_EDGES = 49,
  localparam int unsigned LO_W = 8,
  localparam int unsigned CW   = $clog2(UNLOCK_EDGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  output logic [LO_W-1:0] rom_lo
);
  logic          rst_int_n;
  logic          top_bit_s;
  logic [CW-1:0] edge_cnt;
  logic          unlocked;

  rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  bit_sync #(.STAGES(2)) i_top_sync (
    .clk(clk), .rst_n(rst_int_n), .d(cpu_addr[AW-1]), .q(top_bit_s)
  );

  unlock_ctr #(.UNLOCK_EDGES(UNLOCK_EDGES)) i_unlock (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(top_bit_s),
    .count_o(edge_cnt), .unlocked_o(unlocked)
  );

  hdr_perm #(.AW(AW), .LO_W(LO_W), .WIN_BIT(8)) i_perm (
    .addr_i(cpu_addr), .unlocked_i(unlocked), .lo_o(rom_lo)
  );

  AST_LOCKED_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (edge_cnt != CW'(UNLOCK_EDGES)) |-> rom_lo[LO_W-1]); // R1
  AST_OPEN_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(unlocked) |-> (edge_cnt == CW'(UNLOCK_EDGES))); // R2
  AST_PERM_ONES: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones({rom_lo[6], rom_lo[4], rom_lo[1], rom_lo[0]}) ==
    $countones({cpu_addr[6], cpu_addr[4], cpu_addr[1], cpu_addr[0]})); // R5
endmodule

// File: tb/test_addr_scrambler.sv
module test_addr_scrambler;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  rom_lo;
  int          n_chk;
  int          n_bad;

  addr_scrambler i_addr_scrambler (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rom_lo(rom_lo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] expect_lo(input logic [15:0] a, input logic open);
    logic [7:0] r;
    r = a[7:0];
    if (a[15:9] == 7'd0 && a[8]) begin
      r[0] = a[6]; r[1] = a[4]; r[4] = a[1]; r[6] = a[0];
    end
    if (!open) r[7] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic open);
    cpu_addr = a;
    #1;
    chk(req, rom_lo, expect_lo(a, open));
  endtask

  task automatic do_reset();
    @(negedge clk);
    cpu_addr = 16'h0000;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic pulse_top(input int n);
    for (int i = 0; i < n; i++) begin
      cpu_addr = 16'h8000; wait_cyc(4);
      cpu_addr = 16'h0000; wait_cyc(4);
    end
  endtask

  task automatic t_reset_locked();
    do_reset();
    probe("R1", 16'h2000, 1'b0);
    probe("R1", 16'h207F, 1'b0);
    probe("R1", 16'h00FF, 1'b0);
  endtask

  task automatic t_header_window();
    logic [15:0] pats [6] = '{16'h0141, 16'h0100, 16'h01FF, 16'h0112, 16'h01A9, 16'h0155};
    foreach (pats[k]) probe("R5", pats[k], 1'b0);
    probe("R7", 16'h017F, 1'b0);
    chk("R7", rom_lo[7], 1'b1);
  endtask

  task automatic t_outside();
    logic [15:0] pats [6] = '{16'h0041, 16'h0241, 16'h4141, 16'h0D53, 16'h3F12, 16'h0300};
    foreach (pats[k]) probe("R6", pats[k], 1'b0);
    probe("R8", 16'h012C, 1'b0);
    chk("R8", {5'd0, rom_lo[5], rom_lo[3], rom_lo[2]}, 8'h07);
    probe("R8", 16'h0403, 1'b0);
    chk("R8", {5'd0, rom_lo[5], rom_lo[3], rom_lo[2]}, 8'h00);
  endtask

  task automatic t_other_bits();
    for (int i = 0; i < 60; i++) begin
      cpu_addr = 16'h7F80; wait_cyc(4);
      cpu_addr = 16'h0000; wait_cyc(4);
    end
    probe("R3", 16'h2000, 1'b0);
  endtask

  task automatic t_unlock();
    pulse_top(48);
    probe("R2", 16'h2000, 1'b0);
    probe("R2", 16'h0180, 1'b0);
    pulse_top(1);
    probe("R2", 16'h2000, 1'b1);
    probe("R2", 16'h2080, 1'b1);
    probe("R7", 16'h0100, 1'b1);
    probe("R7", 16'h01C1, 1'b1);
    probe("R8", 16'h002C, 1'b1);
  endtask

  task automatic t_stay_and_relock();
    pulse_top(20);
    probe("R4", 16'h3000, 1'b1);
    probe("R4", 16'h3080, 1'b1);
    do_reset();
    probe("R4", 16'h3000, 1'b0);
    pulse_top(49);
    probe("R4", 16'h3000, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cpu_addr = 16'h0000;
    t_reset_locked();
    t_header_window();
    t_outside();
    t_other_bits();
    t_unlock();
    t_stay_and_relock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule